// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of several hardware threads and arranges them as a stack of overlapping windows. Each window has eight incoming, eight local and eight outgoing registers. A procedure call advances the thread's window pointer. The caller's outgoing registers then appear to the callee as its incoming registers, and no data is moved. A return moves the pointer back. Eight global registers per thread sit outside the window scheme.

A 5-bit architectural register number is combined with the selected thread and that thread's current window to form a physical row. The block serves two combinational reads and one write per cycle, and a read of the row being written returns the new data. Spilling windows to memory and filling them back is handled elsewhere. When the window stack is full or empty, this block only raises a one-cycle flag and leaves the pointer unchanged.

Top module: `winreg_file`

## Requirements
- R1: Register numbers 0 to 7 address eight global registers of the selected thread, and moving the window does not change which registers they reach.
- R2: Numbers 16 to 23 address locals private to the current window: a local written in one window is not visible after a save and is visible again after the matching restore.
- R3: Numbers 8 to 15 (outgoing) of window w are the same storage as numbers 24 to 31 (incoming) of window (w+1) mod 8, register by register, so a value written as outgoing register k before a save reads back as incoming register k after it, and the reverse holds across a restore.
- R4: A save (saveReq high, restoreReq low) advances the selected thread's window pointer by one modulo 8, and a restore moves it back by one. The pointer is visible on curWin in the cycle after the request.
- R5: A thread may hold at most 6 saves that have not been restored. A further save leaves the pointer unchanged, clobbers none of window 0's incoming registers, and pulses overflow for the one cycle after the request.
- R6: A restore with no outstanding save leaves the pointer unchanged and pulses underflow for the one cycle after the request.
- R7: When a read port and the write port reach the same physical register in one cycle, the read returns wrData in that cycle.
- R8: Each thread has its own window pointer and its own register contents, and thrSel chooses which thread every port uses.
- R9: After reset every window pointer is 0, both flags are low and every register reads 0.
- R10: A request with saveReq and restoreReq both high changes no pointer and raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| thrSel | input | 2 | Thread used by all ports this cycle |
| saveReq | input | 1 | Advance the selected thread's window |
| restoreReq | input | 1 | Move the selected thread's window back |
| wrEn | input | 1 | Write enable |
| wrIdx | input | 5 | Architectural register number to write |
| wrData | input | 32 | Write data |
| rdIdxA | input | 5 | Register number for read port A |
| rdIdxB | input | 5 | Register number for read port B |
| rdDataA | output | 32 | Read data, port A |
| rdDataB | output | 32 | Read data, port B |
| curWin | output | 3 | Window pointer of the selected thread |
| overflow | output | 1 | One-cycle pulse: the previous save was refused |
| underflow | output | 1 | One-cycle pulse: the previous restore was refused |

## Verification
A wrong window pointer or depth count shows on curWin one cycle after the faulty request. It also changes which row the next read of a windowed register reaches, so stale or zero data appears at once on rdDataA or rdDataB. A mistake in the aliasing arithmetic stays hidden until a value crosses a save or restore. The bench therefore writes outgoing, local and incoming registers on both sides of each pointer move. A wrong depth limit shows as a missing or early overflow flag, and as a clobbered window-0 incoming register once the stack has unwound.

// File: rtl/wrf_pkg.sv
`timescale 1ns/1ps
package wrf_pkg;

  // Registers per group (global, out, local, in); fixed by the 5-bit index.
  localparam int REG_GROUP = 8;
  localparam int IDX_W     = 5;

  typedef enum logic [1:0] {
    GRP_GLOBAL = 2'd0,
    GRP_OUT    = 2'd1,
    GRP_LOCAL  = 2'd2,
    GRP_IN     = 2'd3
  } regGroup_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic wrGo;
  } wrStrobe_t;

endpackage

// File: rtl/wrf_ctrl.sv
`timescale 1ns/1ps
module wrf_ctrl #(
  parameter int THREADS = 4,
  parameter int WINDOWS = 8,
  localparam int TID_W = $clog2(THREADS),
  localparam int WIN_W = $clog2(WINDOWS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TID_W-1:0]  thrSel,
  input  logic              saveReq,
  input  logic              restoreReq,
  input  logic              wrEn,
  output logic [WIN_W-1:0]  curWin,
  output logic              overflow,
  output logic              underflow,
  output wrf_pkg::wrStrobe_t strb
);

  localparam int DEP_W     = $clog2(WINDOWS);
  localparam int MAX_DEPTH = WINDOWS - 2;

  logic [WIN_W-1:0] cwp   [THREADS];
  logic [DEP_W-1:0] depth [THREADS];

  logic doSave, doRestore, atTop, atBottom;

  assign doSave    = saveReq & ~restoreReq;
  assign doRestore = restoreReq & ~saveReq;
  assign atTop     = (depth[thrSel] == DEP_W'(MAX_DEPTH));
  assign atBottom  = (depth[thrSel] == '0);

  for (genvar g = 0; g < THREADS; g++) begin : gThread
    logic hit;
    assign hit = (thrSel == TID_W'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cwp[g]   <= '0;
        depth[g] <= '0;
      end else if (hit && doSave && !atTop) begin
        cwp[g]   <= cwp[g] + 1'b1;
        depth[g] <= depth[g] + 1'b1;
      end else if (hit && doRestore && !atBottom) begin
        cwp[g]   <= cwp[g] - 1'b1;
        depth[g] <= depth[g] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      overflow  <= doSave & atTop;
      underflow <= doRestore & atBottom;
    end
  end

  assign curWin    = cwp[thrSel];
  assign strb.wrGo = wrEn;

endmodule

// File: rtl/wrf_dpath.sv
`timescale 1ns/1ps
module wrf_dpath #(
  parameter int THREADS  = 4,
  parameter int WINDOWS  = 8,
  parameter int DATA_W   = 32,
  parameter int RD_PORTS = 2,
  localparam int TID_W = $clog2(THREADS),
  localparam int WIN_W = $clog2(WINDOWS),
  localparam int IDX_W = wrf_pkg::IDX_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TID_W-1:0]   thrSel,
  input  logic [WIN_W-1:0]   win,
  input  wrf_pkg::wrStrobe_t strb,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [IDX_W-1:0]   rdIdx  [RD_PORTS],
  output logic [DATA_W-1:0]  rdData [RD_PORTS]
);

  localparam int GRP        = wrf_pkg::REG_GROUP;
  localparam int WIN_ROWS   = 2 * GRP;                 // ins + locals per window
  localparam int ROWS_PER_T = GRP + WINDOWS * WIN_ROWS;
  localparam int ROWS       = THREADS * ROWS_PER_T;
  localparam int ROW_W      = $clog2(ROWS);

  logic [DATA_W-1:0] mem [ROWS];

  function automatic logic [ROW_W-1:0] rowOf(
    input logic [TID_W-1:0] tid,
    input logic [WIN_W-1:0] w,
    input logic [IDX_W-1:0] idx
  );
    logic [WIN_W-1:0] wNext;
    int unsigned      loc;
    int unsigned      r;
    wNext = w + 1'b1;
    r     = 32'(idx[2:0]);
    unique case (wrf_pkg::regGroup_e'(idx[4:3]))
      wrf_pkg::GRP_GLOBAL: loc = r;
      wrf_pkg::GRP_OUT:    loc = GRP + 32'(wNext) * WIN_ROWS + r;
      wrf_pkg::GRP_LOCAL:  loc = GRP + 32'(w) * WIN_ROWS + GRP + r;
      default:             loc = GRP + 32'(w) * WIN_ROWS + r;
    endcase
    return ROW_W'(32'(tid) * ROWS_PER_T + loc);
  endfunction

  logic [ROW_W-1:0] wrRow;
  assign wrRow = rowOf(thrSel, win, wrIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ROWS; i++) mem[i] <= '0;
    end else if (strb.wrGo) begin
      mem[wrRow] <= wrData;
    end
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : gRead
    logic [ROW_W-1:0] rdRow;
    assign rdRow     = rowOf(thrSel, win, rdIdx[p]);
    assign rdData[p] = (strb.wrGo && (rdRow == wrRow)) ? wrData : mem[rdRow];
  end

endmodule

// File: rtl/winreg_file.sv
`timescale 1ns/1ps
module winreg_file #(
  parameter int THREADS = 4,
  parameter int WINDOWS = 8,
  parameter int DATA_W  = 32,
  localparam int TID_W = $clog2(THREADS),
  localparam int WIN_W = $clog2(WINDOWS),
  localparam int IDX_W = wrf_pkg::IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TID_W-1:0]  thrSel,
  input  logic              saveReq,
  input  logic              restoreReq,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdxA,
  input  logic [IDX_W-1:0]  rdIdxB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [WIN_W-1:0]  curWin,
  output logic              overflow,
  output logic              underflow
);

  wrf_pkg::wrStrobe_t strb;
  logic [IDX_W-1:0]  rdIdx  [2];
  logic [DATA_W-1:0] rdData [2];

  assign rdIdx[0] = rdIdxA;
  assign rdIdx[1] = rdIdxB;
  assign rdDataA  = rdData[0];
  assign rdDataB  = rdData[1];

  wrf_ctrl #(.THREADS(THREADS), .WINDOWS(WINDOWS)) uCtrl (
    .clk(clk), .rstN(rstN), .thrSel(thrSel),
    .saveReq(saveReq), .restoreReq(restoreReq), .wrEn(wrEn),
    .curWin(curWin), .overflow(overflow), .underflow(underflow),
    .strb(strb)
  );

  wrf_dpath #(.THREADS(THREADS), .WINDOWS(WINDOWS), .DATA_W(DATA_W), .RD_PORTS(2)) uDpath (
    .clk(clk), .rstN(rstN), .thrSel(thrSel), .win(curWin), .strb(strb),
    .wrIdx(wrIdx), .wrData(wrData), .rdIdx(rdIdx), .rdData(rdData)
  );

endmodule

// File: rtl/wrf_checker.sv
`timescale 1ns/1ps
module wrf_checker #(
  parameter int TID_W  = 2,
  parameter int WIN_W  = 3,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [TID_W-1:0]  thrSel,
  input logic              saveReq,
  input logic              restoreReq,
  input logic              wrEn,
  input logic [4:0]        wrIdx,
  input logic [DATA_W-1:0] wrData,
  input logic [4:0]        rdIdxA,
  input logic [4:0]        rdIdxB,
  input logic [DATA_W-1:0] rdDataA,
  input logic [DATA_W-1:0] rdDataB,
  input logic [WIN_W-1:0]  curWin,
  input logic              overflow,
  input logic              underflow
);

  p_save_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (saveReq && !restoreReq) |=>
      (overflow || thrSel != $past(thrSel) || curWin == $past(curWin) + 1'b1));

  p_restore_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (restoreReq && !saveReq) |=>
      (underflow || thrSel != $past(thrSel) || curWin == $past(curWin) - 1'b1));

  p_ovf_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && thrSel == $past(thrSel)) |-> curWin == $past(curWin));

  p_unf_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (underflow && thrSel == $past(thrSel)) |-> curWin == $past(curWin));

  p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(overflow && underflow));

  p_bypass_a_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && rdIdxA == wrIdx) |-> rdDataA == wrData);

  p_bypass_b_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && rdIdxB == wrIdx) |-> rdDataB == wrData);

  p_both_noop_r10: assert property (@(posedge clk) disable iff (!rstN)
    (saveReq && restoreReq) |=>
      (!overflow && !underflow && (thrSel != $past(thrSel) || curWin == $past(curWin))));

endmodule

bind winreg_file wrf_checker #(.TID_W(TID_W), .WIN_W(WIN_W), .DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .thrSel(thrSel), .saveReq(saveReq), .restoreReq(restoreReq),
  .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData), .rdIdxA(rdIdxA), .rdIdxB(rdIdxB),
  .rdDataA(rdDataA), .rdDataB(rdDataB), .curWin(curWin),
  .overflow(overflow), .underflow(underflow)
);

// File: tb/winreg_file_test.sv
`timescale 1ns/1ps
module winreg_file_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  thrSel = '0;
  logic        saveReq = 1'b0, restoreReq = 1'b0, wrEn = 1'b0;
  logic [4:0]  wrIdx = '0, rdIdxA = '0, rdIdxB = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdDataA, rdDataB;
  logic [2:0]  curWin;
  logic        overflow, underflow;

  always #2 clk = ~clk;

  winreg_file uut (
    .clk(clk), .rstN(rstN), .thrSel(thrSel), .saveReq(saveReq), .restoreReq(restoreReq),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData), .rdIdxA(rdIdxA), .rdIdxB(rdIdxB),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .curWin(curWin),
    .overflow(overflow), .underflow(underflow)
  );

  typedef struct {
    int          due;
    string       req;
    int          sel;   // 0 rdDataA, 1 rdDataB, 2 curWin, 3 overflow, 4 underflow
    logic [31:0] exp;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    nChk = 0;
  int    nFail = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare expected items in the middle of the low clock phase.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0 && q[0].due <= cyc) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.sel)
          0: act = rdDataA;
          1: act = rdDataB;
          2: act = 32'(curWin);
          3: act = 32'(overflow);
          default: act = 32'(underflow);
        endcase
        nChk++;
        if (act !== it.exp) begin
          nFail++;
          $display("FAIL %s sel=%0d cycle=%0d actual=%h expected=%h", it.req, it.sel, cyc, act, it.exp);
        end
      end
    end
  end

  task automatic push(input string req, input int sel, input logic [31:0] exp);
    item_t it;
    it.due = cyc; it.req = req; it.sel = sel; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic drive(input int t, input bit sv, input bit rs, input bit we,
                       input int widx, input logic [31:0] wd, input int ra, input int rb);
    @(negedge clk);
    thrSel = 2'(t); saveReq = sv; restoreReq = rs; wrEn = we;
    wrIdx = 5'(widx); wrData = wd; rdIdxA = 5'(ra); rdIdxB = 5'(rb);
  endtask

  task automatic save(input int t);    drive(t, 1, 0, 0, 0, 0, 0, 0); endtask
  task automatic restore(input int t); drive(t, 0, 1, 0, 0, 0, 0, 0); endtask
  task automatic both(input int t);    drive(t, 1, 1, 0, 0, 0, 0, 0); endtask
  task automatic wr(input int t, input int idx, input logic [31:0] d);
    drive(t, 0, 0, 1, idx, d, 0, 0);
  endtask

  task automatic rd2(input int t, input int a, input logic [31:0] ea,
                     input int b, input logic [31:0] eb, input string req);
    drive(t, 0, 0, 0, 0, 0, a, b);
    push(req, 0, ea); push(req, 1, eb);
  endtask

  task automatic rw(input int t, input int widx, input logic [31:0] wd,
                    input int a, input logic [31:0] ea, input int b, input logic [31:0] eb,
                    input string req);
    drive(t, 0, 0, 1, widx, wd, a, b);
    push(req, 0, ea); push(req, 1, eb);
  endtask

  task automatic win(input int t, input int ew, input bit eo, input bit eu, input string req);
    drive(t, 0, 0, 0, 0, 0, 0, 0);
    push(req, 2, 32'(ew)); push(req, 3, 32'(eo)); push(req, 4, 32'(eu));
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      done = 1'b1;
      nFail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R9: reset state
    for (int t = 0; t < 4; t++) win(t, 0, 0, 0, "R9");
    rd2(0, 3, 32'h0, 25, 32'h0, "R9");

    // R1: global register
    wr(0, 3, 32'hA1);
    rd2(0, 3, 32'hA1, 17, 32'h0, "R1");

    // R7: same-cycle bypass on both ports
    rw(0, 10, 32'h55, 10, 32'h55, 3, 32'hA1, "R7");
    rw(0, 11, 32'h66, 3, 32'hA1, 11, 32'h66, "R7");

    // R3 / R2 across one save and restore
    wr(0, 9, 32'h99); wr(0, 17, 32'h17); wr(0, 25, 32'h25);
    save(0);
    win(0, 1, 0, 0, "R4");
    rd2(0, 25, 32'h99, 9, 32'h0, "R3");
    rd2(0, 26, 32'h55, 27, 32'h66, "R3");
    rd2(0, 17, 32'h0, 3, 32'hA1, "R2 R1");
    wr(0, 9, 32'hB9); wr(0, 17, 32'h71);
    restore(0);
    win(0, 0, 0, 0, "R4");
    rd2(0, 9, 32'h99, 17, 32'h17, "R3 R2");
    rd2(0, 25, 32'h25, 10, 32'h55, "R2");
    save(0);
    wr(0, 25, 32'hC0);
    restore(0);
    rd2(0, 9, 32'hC0, 3, 32'hA1, "R3");

    // R6: underflow on thread 1
    restore(1);
    win(1, 0, 0, 1, "R6");
    win(1, 0, 0, 0, "R6");

    // R4 / R5: fill the stack of thread 1
    for (int k = 1; k <= 5; k++) begin
      save(1);
      win(1, k, 0, 0, "R4");
    end
    wr(1, 8, 32'h58);
    save(1);
    win(1, 6, 0, 0, "R4");
    rd2(1, 24, 32'h58, 8, 32'h0, "R3");
    wr(1, 8, 32'h68);
    save(1);
    win(1, 6, 1, 0, "R5");
    win(1, 6, 0, 0, "R5");
    for (int k = 5; k >= 0; k--) begin
      restore(1);
      win(1, k, 0, 0, "R4");
    end
    rd2(1, 24, 32'h0, 8, 32'h0, "R5");

    // R8: thread independence
    rd2(2, 3, 32'h0, 9, 32'h0, "R8");
    wr(2, 3, 32'hE2);
    rd2(2, 3, 32'hE2, 25, 32'h0, "R8");
    rd2(0, 3, 32'hA1, 25, 32'h25, "R8");
    win(0, 0, 0, 0, "R8");

    // R10: save and restore together
    both(3);
    win(3, 0, 0, 0, "R10");
    save(3);
    both(3);
    win(3, 1, 0, 0, "R10");

    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      nFail++;
      $display("FAIL scoreboard actual=%0d pending expected=0", q.size());
    end
    if (!done) begin
      done = 1'b1;
      summary();
      $finish;
    end
  end

endmodule